// File: doc/BRIEF.md
# Overlapping 1011 Serial Detector

This block samples a one-bit serial stream on every rising clock edge and flags each place where the last four sampled bits read 1, 0, 1, 1 in arrival order. It also flags matches that share bits with an earlier match. It tracks progress as the longest leading part of 1011 that the recent bits end with. From that one stream it builds two independent state machines.

The first machine has four states. Its flag is formed combinationally from its state and the live input bit, so it rises in the same cycle that the closing 1 is present on the input. The second machine has five states, including a dedicated accept state. Its flag is decoded from state alone, so it is high for exactly the one full cycle after the edge that captured the closing 1, and it does not glitch with the input.

The reset is asynchronous and active-low. It puts both machines in their empty-progress state.

Top module: `serial_1011_detector`

## Requirements
- R1: While rst_n is low, both hit_early and hit_late read 0. In the first cycle after release, before any bit has been captured, hit_late reads 0.
- R2: hit_early is 1 in a cycle exactly when the three bits most recently captured since reset were 1, 0, 1 (oldest first) and the present value of din is 1. Otherwise it is 0.
- R3: After a match, the closing 1 counts as the start of the next candidate. The stream 1011011 yields two hit_early pulses, on the 4th and 7th bits.
- R4: A run of 1s keeps the progress at "1" and does not clear it. The stream 111011 yields one hit_early pulse, on its last bit.
- R5: After "10", a 0 clears all progress. The stream 1001011 yields exactly one hit_early pulse, on its last bit.
- R6: After "101", a 0 leaves the progress at "10". The stream 101011 yields one hit_early pulse, on its last bit.
- R7: hit_late is 1 in a cycle exactly when hit_early was 1 in the previous cycle. hit_late is therefore never high for two consecutive cycles.
- R8: From the accept state, the late machine keeps tracking. The stream 10111011 (a 1 after the accept) and the stream 1011011 (a 0 after the accept) each give two hit_late pulses.
- R9: Over every 10-bit stream applied after reset, both outputs agree cycle by cycle with a comparison of a 4-bit shift register against 1011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial data bit, captured at each rising edge |
| hit_early | output | 1 | Combinational same-cycle match flag |
| hit_late | output | 1 | State-decoded match flag, one cycle after hit_early |

## Verification
Directed streams separate the individual transitions:
- 1011011 exposes a machine that returns to start after a match instead of keeping the closing 1.
- 111011 catches a run of 1s that wrongly clears progress.
- 1001011 catches a "100" that wrongly keeps progress.
- 101011 catches a "1010" that drops its "10" tail.
- 10111011 exercises the accept state on an incoming 1.

Every one of the 1024 ten-bit streams is then applied from reset. Both outputs are compared against a shift-register model at every bit, which covers each state/input pair of both machines in many histories.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
  // Progress through 1011 for the same-cycle machine
  typedef enum logic [1:0] {
    ES_NONE  = 2'd0,
    ES_ONE   = 2'd1,
    ES_ONEZ  = 2'd2,
    ES_NEAR  = 2'd3
  } early_st_t;

  // Progress through 1011 for the state-decoded machine
  typedef enum logic [2:0] {
    LS_NONE  = 3'd0,
    LS_ONE   = 3'd1,
    LS_ONEZ  = 3'd2,
    LS_NEAR  = 3'd3,
    LS_ACC   = 3'd4
  } late_st_t;
endpackage

// File: rtl/seqdet_early_fsm.sv
module seqdet_early_fsm
  import seqdet_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  output logic hit
);
  early_st_t cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    hit = 1'b0;
    case (cur_q)
      ES_NONE: nxt = bit_in ? ES_ONE  : ES_NONE;
      ES_ONE:  nxt = bit_in ? ES_ONE  : ES_ONEZ;
      ES_ONEZ: nxt = bit_in ? ES_NEAR : ES_NONE;
      ES_NEAR: begin
        nxt = bit_in ? ES_ONE : ES_ONEZ;
        hit = bit_in;
      end
      default: nxt = ES_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= ES_NONE;
    else        cur_q <= nxt;
  end
endmodule

// File: rtl/seqdet_late_fsm.sv
module seqdet_late_fsm
  import seqdet_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  output logic hit
);
  late_st_t cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    case (cur_q)
      LS_NONE: nxt = bit_in ? LS_ONE  : LS_NONE;
      LS_ONE:  nxt = bit_in ? LS_ONE  : LS_ONEZ;
      LS_ONEZ: nxt = bit_in ? LS_NEAR : LS_NONE;
      LS_NEAR: nxt = bit_in ? LS_ACC  : LS_ONEZ;
      LS_ACC:  nxt = bit_in ? LS_ONE  : LS_ONEZ;
      default: nxt = LS_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= LS_NONE;
    else        cur_q <= nxt;
  end

  // Flag decoded from state only
  assign hit = (cur_q == LS_ACC);
endmodule

// File: rtl/serial_1011_detector.sv
module serial_1011_detector (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic hit_early,
  output logic hit_late
);
  seqdet_early_fsm u_early (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_in (din),
    .hit    (hit_early)
  );

  seqdet_late_fsm u_late (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_in (din),
    .hit    (hit_late)
  );
endmodule

// File: rtl/seqdet_checker.sv
module seqdet_checker (
  input logic clk,
  input logic rst_n,
  input logic din,
  input logic hit_early,
  input logic hit_late
);
  // R1: quiet outputs while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_quiet_in_reset_r1: assert (!hit_early && !hit_late)
        else $error("outputs active during reset");
    end
  end

  // R2: a same-cycle hit needs history 1,0,1 and a live 1
  p_early_history_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_early |-> (din && $past(din) && !$past(din, 2) && $past(din, 3)));

  // R7: late flag follows early flag by one cycle
  p_late_after_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_early |=> hit_late);

  // R7: late flag only where a same-cycle hit preceded it
  p_late_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_late |-> $past(hit_early));

  // R7: late flag lasts a single cycle
  p_late_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_late |=> !hit_late);
endmodule

bind serial_1011_detector seqdet_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .din       (din),
  .hit_early (hit_early),
  .hit_late  (hit_late)
);

// File: tb/tb_serial_1011_detector.sv
`timescale 1ns/1ps
module tb_serial_1011_detector;
  logic clk = 1'b0;
  logic rst_n;
  logic din;
  logic hit_early, hit_late;

  int checks = 0;
  int errors = 0;
  logic [2:0] hist;
  int nbits;
  logic prev_match;
  int early_cnt, late_cnt;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_1011_detector dut (
    .clk(clk), .rst_n(rst_n), .din(din),
    .hit_early(hit_early), .hit_late(hit_late)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; din = 1'b0;
    @(negedge clk); #1;
    chk("R1", hit_early, 1'b0, "early in reset");
    chk("R1", hit_late, 1'b0, "late in reset");
    @(negedge clk);
    rst_n = 1'b1;
    hist = 3'b000; nbits = 0; prev_match = 1'b0;
    early_cnt = 0; late_cnt = 0;
    #1;
    chk("R1", hit_late, 1'b0, "late after release");
  endtask

  // Drive one bit and check both outputs against the shift-register model
  task automatic step(input logic b, input string tag);
    logic exp_e;
    @(negedge clk);
    din = b;
    #1;
    exp_e = (nbits >= 3) && ({hist, b} == 4'b1011);
    chk(tag, hit_early, exp_e, "hit_early");
    chk(tag, hit_late, prev_match, "hit_late");
    if (hit_early === 1'b1) early_cnt++;
    if (hit_late === 1'b1) late_cnt++;
    @(posedge clk);
    hist = {hist[1:0], b};
    nbits++;
    prev_match = exp_e;
  endtask

  task automatic run_str(input string s, input string tag,
                         input int exp_early, input int exp_late);
    do_reset();
    for (int i = 0; i < s.len(); i++) step(s[i] == "1", tag);
    step(1'b0, tag);  // flush so the last late pulse is seen
    chk(tag, early_cnt == exp_early, 1'b1, {"early count for ", s});
    chk(tag, late_cnt == exp_late, 1'b1, {"late count for ", s});
  endtask

  initial begin
    rst_n = 1'b0; din = 1'b0;
    run_str("1011011", "R3", 2, 2);
    run_str("111011", "R4", 1, 1);
    run_str("1001011", "R5", 1, 1);
    run_str("101011", "R6", 1, 1);
    run_str("10111011", "R8", 2, 2);
    run_str("1011011", "R8", 2, 2);
    run_str("10110000", "R7", 1, 1);
    run_str("0000", "R2", 0, 0);
    for (int v = 0; v < 1024; v++) begin
      do_reset();
      for (int k = 9; k >= 0; k--) step(v[k], "R9");
      step(1'b0, "R9");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule